// File: doc/BRIEF.md
# Bus Operand Transfer Sequencer

This block sits between a 16-bit processor core and its external bus. The core hands over one operand transfer: a byte address, an operand size of one, two or four bytes, a direction, and the write data. The sequencer breaks the transfer into as many bus cycles as the alignment and the responding port require. It runs one cycle at a time, and each cycle is held until the bus acknowledges it. Along with each acknowledge the bus reports whether the port that answered is 8 or 16 bits wide.

For every cycle the block drives four things: the current byte address, a two-bit code giving the bytes of the operand still outstanding, the direction, and the write bytes placed on the correct lanes. On reads it collects the returned bytes into a right-justified operand and flags completion. A word or long word at an odd address is misaligned. It is always moved one byte per cycle, and a misaligned long word is handled as two misaligned words in a row. The most significant byte of an operand always sits at its lowest address.

Top module: `operand_bus_sequencer`

## Requirements
- R1: After reset the bus is idle: `bus_cyc` and `done` are 0, `bus_siz` is 00, `bus_addr` and `bus_dout` are 0, `bus_rw` is 1 and `req_ready` is 1.
- R2: During a cycle `bus_siz` gives the operand bytes still outstanding, including those of the current cycle: 01 for one, 10 for two, 11 for three, 00 for four. A cycle acknowledged with code 01 is the last one.
- R3: During a cycle `bus_addr[19:0]` is the byte address of the next outstanding operand byte, and `bus_addr[23:20]` each copy `bus_addr[19]`.
- R4: An aligned word (even address) on a 16-bit port completes in one cycle: the even byte on lanes 15:8 and the odd byte on lanes 7:0.
- R5: A misaligned word on a 16-bit port takes two cycles. The first is at the odd address and uses lanes 7:0. The second is at the address plus one and uses lanes 15:8.
- R6: An aligned long word on a 16-bit port takes two cycles: the most significant word at the given address, then the least significant word at the address plus two.
- R7: A misaligned long word on a 16-bit port takes four one-byte cycles, with the address rising by one each cycle.
- R8: A cycle acknowledged by an 8-bit port moves one byte, taken from lanes 15:8, and the next cycle is at the address plus one.
- R9: On writes, a cycle planned for two bytes drives the lower-addressed byte on 15:8 and the next byte on 7:0. A cycle planned for one byte drives that byte on both lanes. On reads `bus_dout` is 0.
- R10: One clock after the final acknowledge `done` pulses for one clock. From then on, after a read, `rd_data` holds the assembled operand, right-justified and zero-extended, until the next read completes.
- R11: A request is taken only while `req_ready` is 1. A request raised while a transfer is in progress has no effect on the bus cycles or the result. Each cycle's address, size code and write data stay stable until it is acknowledged.
- R12: `bus_rw` is 1 for a read and 0 for a write, and stays constant for the whole transfer.
- R13: `req_size` encoding: 00 byte, 01 word, 10 long word; 11 is handled as a long word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Transfer request |
| req_ready | output | 1 | Sequencer idle, request will be taken |
| req_addr | input | 24 | Operand byte address |
| req_size | input | 2 | Operand size code (R13) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write operand, right-justified |
| bus_cyc | output | 1 | Bus cycle in progress |
| bus_addr | output | 24 | Bus byte address |
| bus_siz | output | 2 | Outstanding-bytes code |
| bus_rw | output | 1 | 1 = read, 0 = write |
| bus_dout | output | 16 | Write data lanes |
| bus_din | input | 16 | Read data lanes |
| bus_ack | input | 1 | Cycle acknowledge |
| bus_port16 | input | 1 | Responding port is 16 bits wide (valid with ack) |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | 32 | Assembled read operand |

## Verification
A wrong outstanding count or byte index inside the sequencer shows up at the very next cycle. It is visible in `bus_siz`, in the address step and in the write lanes, and the per-clock reference comparison catches it there. A wrong stop condition either ends the transfer early or adds a cycle, which the per-transfer cycle counts for each alignment and port-width case expose. A misplaced read byte only appears once `done` fires, and is caught by checking `rd_data` against the operand built from the responder's memory function.

// File: rtl/bts_pkg.sv
package bts_pkg;

    localparam int LANE_W = 8;
    localparam int BUS_W  = 2 * LANE_W;
    localparam int OPND_W = 4 * LANE_W;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10,
        SZ_RSVD = 2'b11
    } op_size_e;

    // Per-transfer control state
    typedef struct packed {
        logic       wr;     // write transfer
        logic       mis;    // misaligned multi-byte operand
        logic [2:0] total;  // operand length in bytes
        logic [2:0] rem;    // bytes still outstanding
        logic [1:0] idx;    // index of next operand byte, 0 = most significant
    } xfer_s;

    function automatic logic [2:0] op_bytes(op_size_e s);
        case (s)
            SZ_BYTE: return 3'd1;
            SZ_WORD: return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    // four outstanding bytes wrap to code 00
    function automatic logic [1:0] siz_code(logic [2:0] rem);
        return rem[1:0];
    endfunction

    // a cycle is planned for two bytes only on an aligned operand at an even address
    function automatic logic two_lane(logic mis, logic a0, logic [2:0] rem);
        return !mis && !a0 && (rem >= 3'd2);
    endfunction

    // byte slot (0 = least significant) holding operand byte idx
    function automatic logic [1:0] slot_of(logic [2:0] total, logic [1:0] idx);
        logic [2:0] s;
        s = total - 3'd1 - {1'b0, idx};
        return s[1:0];
    endfunction

    function automatic logic [LANE_W-1:0] pick(logic [OPND_W-1:0] d, logic [1:0] slot);
        case (slot)
            2'd0:    return d[7:0];
            2'd1:    return d[15:8];
            2'd2:    return d[23:16];
            default: return d[31:24];
        endcase
    endfunction

endpackage

// File: rtl/bts_ctrl.sv
module bts_ctrl
    import bts_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_write,
    input  logic              bus_ack,
    input  logic              bus_port16,
    output logic              busy,
    output xfer_s             st,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              plan_two,
    output logic              took_two,
    output logic              accept,
    output logic              fire,
    output logic              finish,
    output logic              done
);

    logic              busy_q;
    xfer_s             st_q;
    logic [ADDR_W-1:0] addr_q;
    logic              done_q;
    logic [2:0]        step;
    op_size_e          sz;

    assign sz       = op_size_e'(req_size);
    assign accept   = req_valid && !busy_q;
    assign plan_two = two_lane(st_q.mis, addr_q[0], st_q.rem);
    assign took_two = plan_two && bus_port16;
    assign step     = took_two ? 3'd2 : 3'd1;
    assign fire     = busy_q && bus_ack;
    assign finish   = fire && (st_q.rem == step);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            st_q   <= '0;
            addr_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= finish;
            if (accept) begin
                busy_q     <= 1'b1;
                addr_q     <= req_addr;
                st_q.wr    <= req_write;
                st_q.mis   <= (sz != SZ_BYTE) && req_addr[0];
                st_q.total <= op_bytes(sz);
                st_q.rem   <= op_bytes(sz);
                st_q.idx   <= 2'd0;
            end else if (fire) begin
                addr_q   <= addr_q + ADDR_W'(step);
                st_q.rem <= st_q.rem - step;
                st_q.idx <= st_q.idx + step[1:0];
                if (finish) begin
                    busy_q <= 1'b0;
                end
            end
        end
    end

    assign busy     = busy_q;
    assign st       = st_q;
    assign cur_addr = addr_q;
    assign done     = done_q;

endmodule

// File: rtl/bts_lanes.sv
module bts_lanes
    import bts_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [OPND_W-1:0] req_wdata,
    input  logic              busy,
    input  xfer_s             st,
    input  logic              plan_two,
    output logic [BUS_W-1:0]  bus_dout
);

    logic [OPND_W-1:0] wdata_q;
    logic [1:0]        slot_hi;
    logic [1:0]        slot_lo;
    logic [LANE_W-1:0] byte_hi;
    logic [LANE_W-1:0] byte_lo;

    always_ff @(posedge clk) begin
        if (rst) begin
            wdata_q <= '0;
        end else if (accept) begin
            wdata_q <= req_wdata;
        end
    end

    assign slot_hi = slot_of(st.total, st.idx);
    assign slot_lo = slot_of(st.total, st.idx + 2'd1);
    assign byte_hi = pick(wdata_q, slot_hi);
    assign byte_lo = plan_two ? pick(wdata_q, slot_lo) : byte_hi;

    always_comb begin
        if (busy && st.wr) begin
            bus_dout = {byte_hi, byte_lo};
        end else begin
            bus_dout = '0;
        end
    end

endmodule

// File: rtl/bts_gather.sv
module bts_gather
    import bts_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              fire,
    input  logic              finish,
    input  xfer_s             st,
    input  logic              took_two,
    input  logic              bus_port16,
    input  logic              addr0,
    input  logic [BUS_W-1:0]  bus_din,
    output logic [OPND_W-1:0] rd_data
);

    localparam int SLOTS = OPND_W / LANE_W;

    logic [OPND_W-1:0] acc_q;
    logic [OPND_W-1:0] rd_q;
    logic [LANE_W-1:0] nxt [SLOTS];
    logic [OPND_W-1:0] acc_next;
    logic [1:0]        slot_hi;
    logic [1:0]        slot_lo;
    logic [LANE_W-1:0] single;

    assign slot_hi = slot_of(st.total, st.idx);
    assign slot_lo = slot_of(st.total, st.idx + 2'd1);
    // single byte: lower lane only from a 16-bit port at an odd address
    assign single  = (bus_port16 && addr0) ? bus_din[LANE_W-1:0] : bus_din[BUS_W-1:LANE_W];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        always_comb begin
            nxt[g] = acc_q[g*LANE_W +: LANE_W];
            if (slot_hi == 2'(g)) begin
                nxt[g] = took_two ? bus_din[BUS_W-1:LANE_W] : single;
            end else if (took_two && slot_lo == 2'(g)) begin
                nxt[g] = bus_din[LANE_W-1:0];
            end
        end
        assign acc_next[g*LANE_W +: LANE_W] = nxt[g];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            rd_q  <= '0;
        end else begin
            if (accept) begin
                acc_q <= '0;
            end else if (fire) begin
                acc_q <= acc_next;
            end
            if (finish && !st.wr) begin
                rd_q <= acc_next;
            end
        end
    end

    assign rd_data = rd_q;

endmodule

// File: rtl/operand_bus_sequencer.sv
module operand_bus_sequencer
    import bts_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int MIRROR_BIT = 19
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_write,
    input  logic [31:0]       req_wdata,
    output logic              bus_cyc,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        bus_siz,
    output logic              bus_rw,
    output logic [15:0]       bus_dout,
    input  logic [15:0]       bus_din,
    input  logic              bus_ack,
    input  logic              bus_port16,
    output logic              done,
    output logic [31:0]       rd_data
);

    localparam int HI_W = ADDR_W - 1 - MIRROR_BIT;

    logic              busy;
    xfer_s             st;
    logic [ADDR_W-1:0] cur_addr;
    logic [ADDR_W-1:0] shown_addr;
    logic              plan_two;
    logic              took_two;
    logic              accept;
    logic              fire;
    logic              finish;

    bts_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .req_size   (req_size),
        .req_write  (req_write),
        .bus_ack    (bus_ack),
        .bus_port16 (bus_port16),
        .busy       (busy),
        .st         (st),
        .cur_addr   (cur_addr),
        .plan_two   (plan_two),
        .took_two   (took_two),
        .accept     (accept),
        .fire       (fire),
        .finish     (finish),
        .done       (done)
    );

    bts_lanes u_lanes (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .req_wdata (req_wdata),
        .busy      (busy),
        .st        (st),
        .plan_two  (plan_two),
        .bus_dout  (bus_dout)
    );

    bts_gather u_gather (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .fire       (fire),
        .finish     (finish),
        .st         (st),
        .took_two   (took_two),
        .bus_port16 (bus_port16),
        .addr0      (cur_addr[0]),
        .bus_din    (bus_din),
        .rd_data    (rd_data)
    );

    // upper address bits follow the mirror bit
    if (HI_W > 0) begin : g_mirror
        assign shown_addr = {{HI_W{cur_addr[MIRROR_BIT]}}, cur_addr[MIRROR_BIT:0]};
    end else begin : g_plain
        assign shown_addr = cur_addr;
    end

    assign req_ready = !busy;
    assign bus_cyc   = busy;
    assign bus_addr  = busy ? shown_addr : '0;
    assign bus_siz   = busy ? siz_code(st.rem) : 2'b00;
    assign bus_rw    = busy ? !st.wr : 1'b1;

endmodule

// File: rtl/bts_checker.sv
module bts_checker #(
    parameter int ADDR_W     = 24,
    parameter int MIRROR_BIT = 19
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              bus_cyc,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [1:0]        bus_siz,
    input logic              bus_rw,
    input logic [15:0]       bus_dout,
    input logic              bus_ack,
    input logic              bus_port16,
    input logic              done
);

    // R2
    last_code_ends_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_cyc && bus_ack && bus_siz == 2'b01) |=> !bus_cyc);

    // R11
    held_until_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_cyc && !bus_ack) |=> (bus_cyc && $stable(bus_addr) && $stable(bus_siz) && $stable(bus_dout)));

    // R8
    narrow_step_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_cyc && bus_ack && !bus_port16 && bus_siz != 2'b01) |=>
        (bus_cyc && bus_addr[MIRROR_BIT:0] == $past(bus_addr[MIRROR_BIT:0]) + 1'b1));

    // R10
    done_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(bus_cyc && bus_ack) && !bus_cyc && req_ready));

    // R12
    dir_steady_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_cyc && $past(bus_cyc)) |-> $stable(bus_rw));

    // R9
    read_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_cyc && bus_rw) |-> (bus_dout == 16'h0000));

endmodule

bind operand_bus_sequencer bts_checker #(.ADDR_W(ADDR_W), .MIRROR_BIT(MIRROR_BIT)) u_bts_chk (
    .clk        (clk),
    .rst        (rst),
    .req_ready  (req_ready),
    .bus_cyc    (bus_cyc),
    .bus_addr   (bus_addr),
    .bus_siz    (bus_siz),
    .bus_rw     (bus_rw),
    .bus_dout   (bus_dout),
    .bus_ack    (bus_ack),
    .bus_port16 (bus_port16),
    .done       (done)
);

// File: tb/test_operand_bus_sequencer.sv
`timescale 1ns/1ps
module test_operand_bus_sequencer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [23:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        bus_cyc;
    logic [23:0] bus_addr;
    logic [1:0]  bus_siz;
    logic        bus_rw;
    logic [15:0] bus_dout;
    logic [15:0] bus_din = '0;
    logic        bus_ack = 1'b0;
    logic        bus_port16 = 1'b1;
    logic        done;
    logic [31:0] rd_data;

    operand_bus_sequencer i_operand_bus_sequencer (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
        .req_wdata(req_wdata), .bus_cyc(bus_cyc), .bus_addr(bus_addr),
        .bus_siz(bus_siz), .bus_rw(bus_rw), .bus_dout(bus_dout),
        .bus_din(bus_din), .bus_ack(bus_ack), .bus_port16(bus_port16),
        .done(done), .rd_data(rd_data)
    );

    always #2.5 clk = ~clk;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [23:0] mirror(input logic [23:0] a);
        return {{4{a[19]}}, a[19:0]};
    endfunction

    function automatic logic [7:0] mem(input logic [23:0] a);
        return (a[7:0] * 8'd37) + a[15:8] + (a[23:16] ^ 8'h5B);
    endfunction

    function automatic logic [15:0] respond(input logic [23:0] a, input bit wide);
        if (wide) return {mem({a[23:1], 1'b0}), mem({a[23:1], 1'b1})};
        return {mem(a), 8'hA5};
    endfunction

    // ---------------- behavioural reference model ----------------
    bit          m_busy, m_done, m_mis, m_wr;
    int          m_addr, m_rem, m_idx, m_n;
    logic [31:0] m_wd, m_acc, m_rd;

    function automatic logic [7:0] m_byte(input int j);
        return 8'((m_wd >> (8 * (m_n - 1 - j))) & 32'hFF);
    endfunction

    function automatic bit m_two();
        return !m_mis && (m_addr % 2 == 0) && (m_rem >= 2);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_done = 0; m_mis = 0; m_wr = 0;
            m_addr = 0; m_rem = 0; m_idx = 0; m_n = 0;
            m_wd = 0; m_acc = 0; m_rd = 0;
        end else begin
            m_done = 0;
            if (!m_busy && req_valid) begin
                m_busy = 1;
                m_addr = int'(req_addr);
                m_n    = (req_size == 2'b00) ? 1 : (req_size == 2'b01) ? 2 : 4;
                m_rem  = m_n;
                m_idx  = 0;
                m_mis  = (m_n > 1) && req_addr[0];
                m_wr   = req_write;
                m_wd   = req_wdata;
                m_acc  = 0;
            end else if (m_busy && bus_ack) begin
                int mv;
                mv = (bus_port16 && m_two()) ? 2 : 1;
                if (mv == 2) begin
                    m_acc[8*(m_n-1-m_idx) +: 8] = bus_din[15:8];
                    m_acc[8*(m_n-2-m_idx) +: 8] = bus_din[7:0];
                end else begin
                    m_acc[8*(m_n-1-m_idx) +: 8] = (bus_port16 && (m_addr % 2 == 1)) ? bus_din[7:0] : bus_din[15:8];
                end
                m_addr = (m_addr + mv) & 32'hFFFFFF;
                m_rem  = m_rem - mv;
                m_idx  = m_idx + mv;
                if (m_rem == 0) begin
                    m_busy = 0;
                    m_done = 1;
                    if (!m_wr) m_rd = m_acc;
                end
            end
        end
    end

    // per-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst && !finished) begin
            logic [23:0] ea;
            logic [15:0] ed;
            ea = m_busy ? mirror(24'(m_addr)) : 24'h0;
            ed = 16'h0;
            if (m_busy && m_wr) ed = {m_byte(m_idx), m_two() ? m_byte(m_idx + 1) : m_byte(m_idx)};
            chk(bus_cyc == m_busy && req_ready == !m_busy, "R11 cyc/ready", {30'b0, bus_cyc, req_ready}, {30'b0, m_busy, !m_busy});
            chk(bus_addr == ea, "R3 bus_addr", 32'(bus_addr), 32'(ea));
            chk(bus_siz == (m_busy ? 2'(m_rem % 4) : 2'b00), "R2 bus_siz", 32'(bus_siz), 32'(m_busy ? m_rem % 4 : 0));
            chk(bus_dout == ed, "R9 bus_dout", 32'(bus_dout), 32'(ed));
            chk(bus_rw == (m_busy ? !m_wr : 1'b1), "R12 bus_rw", 32'(bus_rw), 32'(m_busy ? !m_wr : 1'b1));
            chk(done == m_done, "R10 done", 32'(done), 32'(m_done));
            chk(rd_data == m_rd, "R10 rd_data", rd_data, m_rd);
        end
    end

    // ---------------- stimulus ----------------
    // pmode: 0 = 8-bit port, 1 = 16-bit port, 2 = random per cycle
    task automatic run_op(input logic [23:0] a, input logic [1:0] sz, input bit wr,
                          input logic [31:0] wd, input int pmode, input int exp_cyc, input string tag);
        int cyc = 0;
        int guard = 0;
        int n;
        logic [31:0] expv = 0;
        n = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
        for (int j = 0; j < n; j++) expv = (expv << 8) | 32'(mem(mirror(a + 24'(j))));
        @(negedge clk);
        req_addr = a; req_size = sz; req_write = wr; req_wdata = wd; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (1) begin
            if (done) break;
            if (bus_cyc && $urandom_range(0, 2) != 0) begin
                bus_ack    = 1'b1;
                bus_port16 = (pmode == 2) ? 1'($urandom_range(0, 1)) : 1'(pmode);
                bus_din    = respond(bus_addr, bus_port16);
            end else begin
                bus_ack = 1'b0;
                bus_din = 16'($urandom);
            end
            // R11: unrelated request while busy
            req_valid = bus_cyc && ($urandom_range(0, 3) == 0);
            req_addr  = 24'($urandom); req_size = 2'($urandom); req_write = 1'($urandom); req_wdata = $urandom;
            @(negedge clk);
            if (bus_ack) cyc++;
            guard++;
            if (guard > 200) begin
                chk(1'b0, {tag, " hang"}, 32'(guard), 32'd0);
                break;
            end
        end
        bus_ack = 1'b0; req_valid = 1'b0;
        if (exp_cyc >= 0) chk(cyc == exp_cyc, {tag, " cycles"}, 32'(cyc), 32'(exp_cyc));
        if (!wr) chk(rd_data == expv, {tag, " R10 operand"}, rd_data, expv);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(!bus_cyc && !done && req_ready && bus_rw && bus_siz == 2'b00 && bus_addr == 0 && bus_dout == 0,
            "R1 reset state", {27'b0, bus_cyc, done, req_ready, bus_siz}, 32'h0000_0004);

        run_op(24'h000100, 2'b01, 1'b0, 32'h0, 1, 1, "R4 aligned word");
        run_op(24'h000101, 2'b01, 1'b0, 32'h0, 1, 2, "R5 misaligned word");
        run_op(24'h000200, 2'b10, 1'b0, 32'h0, 1, 2, "R6 aligned long");
        run_op(24'h000301, 2'b10, 1'b0, 32'h0, 1, 4, "R7 misaligned long");
        run_op(24'h000400, 2'b10, 1'b0, 32'h0, 0, 4, "R8 long on 8-bit port");
        run_op(24'h000503, 2'b01, 1'b0, 32'h0, 0, 2, "R8 word on 8-bit port");
        run_op(24'h000601, 2'b00, 1'b0, 32'h0, 1, 1, "R5 odd byte");
        run_op(24'h000602, 2'b00, 1'b0, 32'h0, 1, 1, "R4 even byte");
        run_op(24'h000701, 2'b10, 1'b1, 32'h11223344, 1, 4, "R9 misaligned long write");
        run_op(24'h000800, 2'b01, 1'b1, 32'h0000A1B2, 1, 1, "R9 aligned word write");
        run_op(24'h000900, 2'b10, 1'b1, 32'hCAFE1234, 0, 4, "R9 long write 8-bit port");
        run_op(24'h080000, 2'b01, 1'b0, 32'h0, 1, 1, "R3 mirrored high bits");
        run_op(24'h0FFFFF, 2'b10, 1'b0, 32'h0, 1, 4, "R3 wrap past mirror bit");
        run_op(24'h000A00, 2'b11, 1'b0, 32'h0, 1, 2, "R13 reserved size");
        for (int i = 0; i < 60; i++) begin
            run_op(24'($urandom), 2'($urandom), 1'($urandom), $urandom, 2, -1, "random R2");
        end
        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule